// File: doc/BRIEF.md
# Page-Table Reference-Bit Sweeper

This block ages the page table for a simple least-recently-used replacement policy. A timer event starts a hardware sweep. The sweep walks every page-table word in memory, starting at a base address, and clears the reference flag (bit 0) of each word. All other bits of each word stay exactly as they were. The sweep covers the kernel-only pages as well as the user pages. Replacement decisions and address translation happen elsewhere.

The block reaches memory through one request port with a ready signal, so an arbiter shared with the translation unit can stall it at any time. Reads return on a separate response strobe after any latency. For each entry the block reads the word, then writes it back with bit 0 cleared. When the reference flag is already clear, that write is skipped. The block shows `busy` while it works and gives a one-cycle `done` pulse at the end.

Top module: `refbit_sweeper`

## Requirements
- R1: After reset, `busy`, `done` and `memReqValid` are all 0.
- R2: A `tick` seen while `busy` and `done` are both 0 starts a sweep. `busy` is 1 in the next cycle, and `tableBase` is sampled on that same edge.
- R3: A sweep issues exactly one read to each of the 16 words base+0 to base+15, in ascending address order.
- R4: A write (`memReqWrite`=1) sends the word just read back to the same address, with bit 0 forced to 0 and bits 15:1 unchanged.
- R5: Memory words outside base+0 to base+15 are never written.
- R6: A request holds `memReqValid`, address, direction and data until `memReqReady` accepts it. A read then waits for `memRspValid`, whatever the latency, before the block moves on.
- R7: When a word reads back with bit 0 already 0, no write is issued for it. The entry still counts as one of the 16.
- R8: `done` is 1 for exactly one cycle. That cycle follows the acceptance of the final entry's write, or the final entry's read response when its write is skipped. `busy` is 0 in the `done` cycle.
- R9: A `tick` while `busy` or `done` is 1 is ignored. No further requests follow the sweep in progress.
- R10: Changes on `tableBase` during a sweep do not affect the addresses of that sweep.
- R11: `memReqValid` is 1 only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer event that starts a sweep |
| tableBase | input | 16 | Word address of the first page-table entry |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | 16 | Request word address |
| memReqWdata | output | 16 | Write data |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 16 | Read data |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The assertions assume the memory side is well behaved. There is exactly one `memRspValid` for each accepted read, and it is never raised unprompted. There is no response to a write, and table addresses do not wrap past the top of the address space. The bench memory model returns one response per accepted read after a programmable delay and ignores writes for response purposes. All bases used lie well inside a 256-word model, so the wrap case never arises. `memReqReady` is either held high or follows a repeating stall pattern. Triggers are driven mid-sweep and during the `done` cycle to exercise the cases that must be ignored.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_DONE
  } sweepState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBase;
    logic clrIdx;
    logic incIdx;
    logic capData;
  } sweepStrobe_t;

endpackage

// File: rtl/sweep_dpath.sv
module sweep_dpath
  import sweep_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int NUM_ENTRIES = 16,
  parameter int REF_BIT     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepStrobe_t      strobe,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  output logic              lastEntry
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] clearMask;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      if (b == REF_BIT) begin : g_ref
        assign clearMask[b] = 1'b0;
      end else begin : g_keep
        assign clearMask[b] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      idxQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobe.loadBase) baseQ <= tableBase;
      if (strobe.clrIdx)       idxQ <= '0;
      else if (strobe.incIdx)  idxQ <= idxQ + 1'b1;
      if (strobe.capData) dataQ <= rspData;
    end
  end

  assign reqAddr   = baseQ + ADDR_W'(idxQ);
  assign reqWdata  = dataQ & clearMask;
  assign lastEntry = (idxQ == LAST_IDX);

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter bit SKIP_CLEAN = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         reqReady,
  input  logic         rspValid,
  input  logic         rspRef,
  input  logic         lastEntry,
  output sweepStrobe_t strobe,
  output logic         reqValid,
  output logic         reqWrite,
  output logic         busy,
  output logic         done
);
  sweepState_t stateQ, stateD;
  logic needWrite;

  generate
    if (SKIP_CLEAN) begin : g_skip
      assign needWrite = rspRef;
    end else begin : g_always
      assign needWrite = 1'b1;
    end
  endgenerate

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (tick) begin
        strobe.loadBase = 1'b1;
        strobe.clrIdx   = 1'b1;
        stateD          = ST_RD_REQ;
      end
      ST_RD_REQ: if (reqReady) stateD = ST_RD_WAIT;
      ST_RD_WAIT: if (rspValid) begin
        strobe.capData = 1'b1;
        if (needWrite)      stateD = ST_WR_REQ;
        else if (lastEntry) stateD = ST_DONE;
        else begin
          strobe.incIdx = 1'b1;
          stateD        = ST_RD_REQ;
        end
      end
      ST_WR_REQ: if (reqReady) begin
        if (lastEntry) stateD = ST_DONE;
        else begin
          strobe.incIdx = 1'b1;
          stateD        = ST_RD_REQ;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqValid = (stateQ == ST_RD_REQ) || (stateQ == ST_WR_REQ);
  assign reqWrite = (stateQ == ST_WR_REQ);
  assign busy     = (stateQ == ST_RD_REQ) || (stateQ == ST_RD_WAIT) || (stateQ == ST_WR_REQ);
  assign done     = (stateQ == ST_DONE);

endmodule

// File: rtl/refbit_sweeper.sv
module refbit_sweeper
  import sweep_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int NUM_ENTRIES = 16,
  parameter int REF_BIT     = 0,
  parameter bit SKIP_CLEAN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] tableBase,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              busy,
  output logic              done
);
  sweepStrobe_t strobe;
  logic lastEntry;

  sweep_ctrl #(.SKIP_CLEAN(SKIP_CLEAN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .reqReady (memReqReady),
    .rspValid (memRspValid),
    .rspRef   (memRspData[REF_BIT]),
    .lastEntry(lastEntry),
    .strobe   (strobe),
    .reqValid (memReqValid),
    .reqWrite (memReqWrite),
    .busy     (busy),
    .done     (done)
  );

  sweep_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES), .REF_BIT(REF_BIT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tableBase(tableBase),
    .rspData  (memRspData),
    .reqAddr  (memReqAddr),
    .reqWdata (memReqWdata),
    .lastEntry(lastEntry)
  );

endmodule

// File: rtl/sweep_chk.sv
module sweep_chk #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int NUM_ENTRIES = 16,
  parameter int REF_BIT     = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic [ADDR_W-1:0] tableBase,
  input logic              memReqValid,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWdata,
  input logic              memReqReady,
  input logic              memRspValid,
  input logic [DATA_W-1:0] memRspData,
  input logic              busy,
  input logic              done
);
  logic [ADDR_W-1:0] obsBase;
  logic [ADDR_W-1:0] obsRdAddr;
  logic [DATA_W-1:0] obsRdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      obsBase   <= '0;
      obsRdAddr <= '0;
      obsRdData <= '0;
    end else begin
      if (tick && !busy && !done) obsBase <= tableBase;
      if (memReqValid && memReqReady && !memReqWrite) obsRdAddr <= memReqAddr;
      if (memRspValid) obsRdData <= memRspData;
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !busy && !done) |=> busy);

  // R4
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (memReqAddr == obsRdAddr));

  // R4
  wr_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |->
      (memReqWdata[REF_BIT] == 1'b0) &&
      ((memReqWdata | DATA_W'(1) << REF_BIT) == (obsRdData | DATA_W'(1) << REF_BIT)));

  // R5
  addr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (ADDR_W'(memReqAddr - obsBase) < ADDR_W'(NUM_ENTRIES)));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite) && $stable(memReqWdata)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

endmodule

bind refbit_sweeper sweep_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES), .REF_BIT(REF_BIT)
) u_sweep_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .tableBase(tableBase),
  .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
  .memReqWdata(memReqWdata), .memReqReady(memReqReady), .memRspValid(memRspValid),
  .memRspData(memRspData), .busy(busy), .done(done)
);

// File: tb/test_refbit_sweeper.sv
module test_refbit_sweeper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] tableBase = '0;
  logic        memReqValid, memReqWrite;
  logic [15:0] memReqAddr, memReqWdata;
  logic        memReqReady = 1'b1;
  logic        memRspValid = 1'b0;
  logic [15:0] memRspData = '0;
  logic        busy, done;

  always #10 clk = ~clk;

  refbit_sweeper i_refbit_sweeper (
    .clk(clk), .rstN(rstN), .tick(tick), .tableBase(tableBase),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .busy(busy), .done(done)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] mem [0:255];
  logic [15:0] expMem [0:255];
  logic [15:0] rdLog [0:63];
  int rdN = 0, wrN = 0, doneCnt = 0;
  int rspDelay = 0;
  bit stallOn = 1'b0;
  int stallCnt = 0;
  logic [15:0] curBase = '0;
  logic [7:0]  pendAddr = '0;
  int pendCnt = 0;
  bit expDoneNext = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model and done monitor
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (rstN) begin
      if (expDoneNext || done) begin
        check(done == expDoneNext, "R8 done timing", {31'd0, done}, {31'd0, expDoneNext});
        check(!(done && busy), "R8 busy low in done cycle", {31'd0, busy}, 32'd0);
      end
      if (done) doneCnt++;
      expDoneNext <= 1'b0;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr[7:0]] <= memReqWdata;
          wrN++;
          if (memReqAddr == curBase + 16'd15) expDoneNext <= 1'b1;
        end else begin
          if (rdN < 64) rdLog[rdN] = memReqAddr;
          rdN++;
          pendAddr <= memReqAddr[7:0];
          pendCnt  <= rspDelay + 1;
        end
      end
      if (pendCnt == 1) begin
        memRspValid <= 1'b1;
        memRspData  <= mem[pendAddr];
      end
      if (pendCnt != 0) pendCnt <= pendCnt - 1;
      if (memRspValid && ({8'd0, pendAddr} == curBase + 16'd15) && !memRspData[0])
        expDoneNext <= 1'b1;
    end
  end

  always @(negedge clk) begin
    stallCnt++;
    memReqReady <= stallOn ? ((stallCnt % 3) != 0) : 1'b1;
  end

  task automatic fillTable(input logic [15:0] base, input bit alternate);
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1D37) ^ 16'hA5C3;
    for (int i = 0; i < 16; i++)
      if (alternate && (i % 2 == 1)) mem[base[7:0] + i] = mem[base[7:0] + i] & 16'hFFFE;
    for (int i = 0; i < 256; i++) expMem[i] = mem[i];
  endtask

  task automatic startSweep(input logic [15:0] base);
    curBase = base;
    tableBase = base;
    rdN = 0; wrN = 0; doneCnt = 0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(busy == 1'b1, "R2 busy after trigger", {31'd0, busy}, 32'd1);
  endtask

  task automatic waitDone();
    int lim = 0;
    while (doneCnt == 0 && lim < 2000) begin @(negedge clk); lim++; end
    check(doneCnt == 1, "R8 sweep finished", doneCnt, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic verifyTable(input logic [15:0] base, input string tag);
    int expWr = 0;
    check(rdN == 16, {tag, " R3 read count"}, rdN, 32'd16);
    for (int i = 0; i < 16; i++) begin
      check(rdLog[i] == base + 16'(i), {tag, " R3 ascending order"}, rdLog[i], base + 16'(i));
      check(mem[base[7:0] + i] == (expMem[base[7:0] + i] & 16'hFFFE), {tag, " R4 entry cleared"},
            mem[base[7:0] + i], expMem[base[7:0] + i] & 16'hFFFE);
      if (expMem[base[7:0] + i][0]) expWr++;
    end
    check(wrN == expWr, {tag, " R7 write count"}, wrN, expWr);
    check(mem[base[7:0] - 1] == expMem[base[7:0] - 1], {tag, " R5 below window"},
          mem[base[7:0] - 1], expMem[base[7:0] - 1]);
    check(mem[base[7:0] + 16] == expMem[base[7:0] + 16], {tag, " R5 above window"},
          mem[base[7:0] + 16], expMem[base[7:0] + 16]);
  endtask

  task automatic testReset();
    check(busy == 0, "R1 busy at reset", {31'd0, busy}, 0);
    check(done == 0, "R1 done at reset", {31'd0, done}, 0);
    check(memReqValid == 0, "R1 no request at reset", {31'd0, memReqValid}, 0);
  endtask

  task automatic testPlain();
    stallOn = 0; rspDelay = 0;
    fillTable(16'h0040, 1'b0);
    startSweep(16'h0040);
    waitDone();
    verifyTable(16'h0040, "plain");
  endtask

  task automatic testStall();
    stallOn = 1; rspDelay = 3;
    fillTable(16'h0010, 1'b0);
    startSweep(16'h0010);
    waitDone();
    verifyTable(16'h0010, "R6 stalled");
    stallOn = 0; rspDelay = 0;
  endtask

  task automatic testSkip();
    fillTable(16'h0080, 1'b1);
    startSweep(16'h0080);
    waitDone();
    verifyTable(16'h0080, "R7 skip");
    check(wrN == 8, "R7 half the entries written", wrN, 8);
  endtask

  task automatic testRetrigger();
    stallOn = 1; rspDelay = 1;
    fillTable(16'h0020, 1'b0);
    startSweep(16'h0020);
    repeat (5) @(negedge clk);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    begin
      int lim = 0;
      while (!done && lim < 2000) begin @(negedge clk); lim++; end
    end
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    repeat (40) @(negedge clk);
    check(busy == 0, "R9 no restart", {31'd0, busy}, 0);
    check(rdN == 16, "R9 read count unchanged", rdN, 16);
    check(doneCnt == 1, "R9 single done", doneCnt, 1);
    verifyTable(16'h0020, "R9 retrigger");
    stallOn = 0; rspDelay = 0;
  endtask

  task automatic testBaseChange();
    fillTable(16'h0060, 1'b0);
    startSweep(16'h0060);
    repeat (2) @(negedge clk);
    tableBase = 16'h00A0;
    waitDone();
    verifyTable(16'h0060, "R10 base change");
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    check(1'b0, "watchdog expired", wd, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testPlain();
    testStall();
    testSkip();
    testRetrigger();
    testBaseChange();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule